// File: doc/BRIEF.md
# Bundle Issue Group Former

This block sits between instruction fetch and the execution pipelines of a statically scheduled core. It takes in 128-bit instruction bundles, one per handshake. Each bundle carries three 41-bit operations and a 5-bit template code. The template tells the block which functional-unit class each operation needs and where the compiler has placed issue barriers.

The block looks only at the template. It never compares register fields. Operations are held in a short in-order slot queue. Every cycle a group is taken from the head of that queue. A group may span two bundles and holds at most six operations. It ends at a barrier, at the end of the buffered operations, or just before a third operation of any one unit class. Whatever is left, including the slots that follow a barrier placed inside a bundle, leads the next group.

A group is presented on six output lanes with a valid-ready handshake. Each lane carries its valid bit, its unit class and the raw operation. Operand decode and execution belong to the stages that follow.

Top module: `ig_issue_former`

## Requirements
- R1: Bundle layout is template in bits [4:0], slot 0 in [45:5], slot 1 in [86:46] and slot 2 in [127:87]. Operations leave in slot order and in arrival order on lanes 0 upward, each as the unmodified 41-bit field. Lanes that are not valid carry class 0 and operation 0.
- R2: Template bits [4:2] select the slot classes, written as slot 0, slot 1, slot 2. The codes are: 0 = MEM INT INT, 1 = MEM MEM INT, 2 = MEM FPU INT, 3 = MEM INT BRANCH, 4 = MEM FPU BRANCH, 5 = INT INT BRANCH, 6 = MEM MEM FPU. Class encoding on the output is INT=0, MEM=1, FPU=2, BRANCH=3.
- R3: Template bit 0 places a barrier after slot 2. No operation of a later bundle joins the group that contains that slot.
- R4: Template bit 1 places a barrier after slot 1. The group ends after slot 1, and slot 2 becomes lane 0 of the next group.
- R5: Without a barrier, a group continues across a bundle boundary, up to six operations.
- R6: A group holds at most two operations of any one class. The group ends before the first operation that would exceed this, and that operation leads the next group.
- R7: A bundle with template bits [4:2] = 7 is reserved. It is accepted, none of its operations are issued, and `bad_bundle` is high in the cycle after acceptance.
- R8: `in_ready` is low while more than three operations are buffered. A bundle offered while `in_ready` is low is not taken and never appears on the outputs.
- R9: `out_valid` is high while any operation is buffered. While `out_ready` is low the offered group is held. A transfer removes exactly the lanes marked valid.
- R10: After reset the queue is empty, `out_valid` and `bad_bundle` are low and `in_ready` is high.
- R11: A bundle can be accepted in the same cycle that a group is issued. The new bundle then forms the following group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Room for one more bundle |
| in_bundle | input | 128 | Template and three operation slots |
| out_valid | output | 1 | A group is offered |
| out_ready | input | 1 | Consumer takes the offered group |
| out_slot_valid | output | 6 | Per-lane valid, lane 0 oldest |
| out_slot_class | output | 12 | Per-lane unit class, 2 bits per lane |
| out_slot_op | output | 246 | Per-lane raw operation, 41 bits per lane |
| bad_bundle | output | 1 | Reserved template seen in the previous cycle |

## Verification
Two things can happen in the same cycle: taking in a new bundle and retiring an issued group. When both do, the queue shifts and appends at once. The new slots must land directly behind the survivors of the retired group. The bench provokes this by holding `in_valid` and `out_ready` high over one edge, with one barrier-terminated bundle already queued. It then requires the next offered group to be exactly the new bundle's three operations, with their classes. Unit-class limits and barriers placed inside a bundle are each checked on two-bundle mixes. These are preloaded under backpressure, so that the expected cut is fixed.

// File: rtl/ig_pkg.sv
package ig_pkg;

    localparam int OP_W     = 41;
    localparam int TPL_W    = 5;
    localparam int SLOTS    = 3;
    localparam int BUNDLE_W = TPL_W + SLOTS * OP_W;
    localparam int CLS_W    = 2;
    localparam int N_CLS    = 4;

    typedef enum logic [CLS_W-1:0] {
        CLS_INT = 2'd0,
        CLS_MEM = 2'd1,
        CLS_FPU = 2'd2,
        CLS_BR  = 2'd3
    } unit_cls_e;

    typedef struct packed {
        logic [OP_W-1:0] op;
        unit_cls_e       cls;
        logic            stop;
    } slot_t;

    localparam logic [2:0] PAT_RESERVED = 3'd7;

    // Classes of slot 0 at [1:0], slot 1 at [3:2], slot 2 at [5:4].
    function automatic logic [SLOTS*CLS_W-1:0] pattern_classes(logic [2:0] pat);
        case (pat)
            3'd0:    return {CLS_INT, CLS_INT, CLS_MEM};
            3'd1:    return {CLS_INT, CLS_MEM, CLS_MEM};
            3'd2:    return {CLS_INT, CLS_FPU, CLS_MEM};
            3'd3:    return {CLS_BR,  CLS_INT, CLS_MEM};
            3'd4:    return {CLS_BR,  CLS_FPU, CLS_MEM};
            3'd5:    return {CLS_BR,  CLS_INT, CLS_INT};
            3'd6:    return {CLS_FPU, CLS_MEM, CLS_MEM};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/ig_tpl_decode.sv
module ig_tpl_decode
    import ig_pkg::*;
(
    input  logic [BUNDLE_W-1:0] bundle,
    output slot_t               slots [SLOTS],
    output logic                illegal
);

    logic [TPL_W-1:0]         code;
    logic [SLOTS*CLS_W-1:0]   cls_vec;

    always_comb begin
        code    = bundle[TPL_W-1:0];
        cls_vec = pattern_classes(code[4:2]);
        illegal = (code[4:2] == PAT_RESERVED);
        for (int s = 0; s < SLOTS; s++) begin
            slots[s].op  = bundle[TPL_W + s*OP_W +: OP_W];
            slots[s].cls = unit_cls_e'(cls_vec[s*CLS_W +: CLS_W]);
        end
        slots[0].stop = 1'b0;
        slots[1].stop = code[1];
        slots[2].stop = code[0];
    end

endmodule

// File: rtl/ig_group_pick.sv
module ig_group_pick
    import ig_pkg::*;
#(
    parameter int DEPTH   = 6,
    parameter int ISSUE_W = 6,
    parameter int UNITS   = 2,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int NW     = $clog2(ISSUE_W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  slot_t         q [DEPTH],
    input  logic [CW-1:0] count,
    output logic [ISSUE_W-1:0] take,
    output logic [NW-1:0] n_take
);

    always_comb begin
        logic blocked;
        int   same;
        int   total;
        blocked = 1'b0;
        total   = 0;
        take    = '0;
        for (int i = 0; i < ISSUE_W; i++) begin
            same = 0;
            for (int j = 0; j < i; j++) begin
                if (q[j].cls == q[i].cls) same++;
            end
            if (!blocked && i < int'(count) && same < UNITS) begin
                take[i] = 1'b1;
                total++;
                if (q[i].stop) blocked = 1'b1;
            end else begin
                blocked = 1'b1;
            end
        end
        n_take = NW'(total);
    end

    // Unit budget per class in every offered group (R6).
    for (genvar c = 0; c < N_CLS; c++) begin : g_cap
        logic [ISSUE_W-1:0] hit;
        always_comb begin
            for (int i = 0; i < ISSUE_W; i++)
                hit[i] = take[i] && (q[i].cls == unit_cls_e'(c));
        end
        p_unit_cap_r6: assert property (@(posedge clk) disable iff (rst)
            $countones(hit) <= UNITS);
    end

    // No lane after a barrier may be taken (R3, R4).
    for (genvar i = 0; i < ISSUE_W - 1; i++) begin : g_cut
        p_stop_cut_r4: assert property (@(posedge clk) disable iff (rst)
            (take[i] && q[i].stop) |-> !take[i+1]);
    end

endmodule

// File: rtl/ig_slot_queue.sv
module ig_slot_queue
    import ig_pkg::*;
#(
    parameter int DEPTH   = 6,
    parameter int ISSUE_W = 6,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int NW     = $clog2(ISSUE_W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_en,
    input  slot_t         push_slots [SLOTS],
    input  logic [NW-1:0] pop_n,
    output slot_t         q [DEPTH],
    output logic [CW-1:0] count
);

    slot_t         q_nxt [DEPTH];
    logic [CW-1:0] count_nxt;

    always_comb begin
        int base;
        int src;
        base = int'(count) - int'(pop_n);
        for (int i = 0; i < DEPTH; i++) begin
            src = i + int'(pop_n);
            if (src < DEPTH) q_nxt[i] = q[src];
            else             q_nxt[i] = '0;
            if (push_en && i >= base && i < base + SLOTS)
                q_nxt[i] = push_slots[i - base];
        end
        count_nxt = CW'(base + (push_en ? SLOTS : 0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            count <= count_nxt;
            for (int i = 0; i < DEPTH; i++) q[i] <= q_nxt[i];
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);

endmodule

// File: rtl/ig_issue_former.sv
module ig_issue_former
    import ig_pkg::*;
#(
    parameter int DEPTH   = 6,
    parameter int ISSUE_W = 6,
    parameter int UNITS   = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [BUNDLE_W-1:0]        in_bundle,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [ISSUE_W-1:0]         out_slot_valid,
    output logic [ISSUE_W*CLS_W-1:0]   out_slot_class,
    output logic [ISSUE_W*OP_W-1:0]    out_slot_op,
    output logic                       bad_bundle
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int NW = $clog2(ISSUE_W + 1);

    slot_t               dec_slots [SLOTS];
    logic                dec_illegal;
    slot_t               q [DEPTH];
    logic [CW-1:0]       count;
    logic [ISSUE_W-1:0]  take;
    logic [NW-1:0]       n_take;
    logic                accept;
    logic                fire;
    logic [NW-1:0]       pop_n;

    ig_tpl_decode u_dec (
        .bundle  (in_bundle),
        .slots   (dec_slots),
        .illegal (dec_illegal)
    );

    ig_slot_queue #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push_en    (accept && !dec_illegal),
        .push_slots (dec_slots),
        .pop_n      (pop_n),
        .q          (q),
        .count      (count)
    );

    ig_group_pick #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .UNITS(UNITS)) u_pick (
        .clk    (clk),
        .rst    (rst),
        .q      (q),
        .count  (count),
        .take   (take),
        .n_take (n_take)
    );

    assign in_ready  = int'(count) <= DEPTH - SLOTS;
    assign accept    = in_valid && in_ready;
    assign out_valid = (count != '0);
    assign fire      = out_valid && out_ready;
    assign pop_n     = fire ? n_take : '0;

    always_comb begin
        for (int i = 0; i < ISSUE_W; i++) begin
            out_slot_valid[i] = take[i];
            out_slot_class[i*CLS_W +: CLS_W] = take[i] ? q[i].cls : CLS_INT;
            out_slot_op[i*OP_W +: OP_W]      = take[i] ? q[i].op : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bad_bundle <= 1'b0;
        else     bad_bundle <= accept && dec_illegal;
    end

    p_bad_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_bundle[4:2] == PAT_RESERVED) |=> bad_bundle);

    p_hold_head_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_slot_op[OP_W-1:0])));

    p_head_valid_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_slot_valid[0]);

    initial begin
        assert (DEPTH >= ISSUE_W && DEPTH >= SLOTS && UNITS >= 1)
            else $error("ig_issue_former: bad parameters");
    end

endmodule

// File: tb/ig_issue_former_test.sv
module ig_issue_former_test;
    import ig_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int IW = 6;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [BUNDLE_W-1:0]  in_bundle = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic [IW-1:0]        out_slot_valid;
    logic [IW*CLS_W-1:0]  out_slot_class;
    logic [IW*OP_W-1:0]   out_slot_op;
    logic                 bad_bundle;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ig_issue_former uut (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_bundle      (in_bundle),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_slot_valid (out_slot_valid),
        .out_slot_class (out_slot_class),
        .out_slot_op    (out_slot_op),
        .bad_bundle     (bad_bundle)
    );

    function automatic logic [OP_W-1:0] opv(int k);
        return {9'(k), 32'hC0DE_0000 + 32'(k)};
    endfunction

    function automatic logic [BUNDLE_W-1:0] mkb(logic [4:0] code, int k);
        return {opv(k+2), opv(k+1), opv(k), code};
    endfunction

    function automatic logic [IW*CLS_W-1:0] cv(int c0, int c1, int c2, int c3, int c4, int c5);
        return {2'(c5), 2'(c4), 2'(c3), 2'(c2), 2'(c1), 2'(c0)};
    endfunction

    function automatic logic [IW*OP_W-1:0] ov(int n, int k0, int k1, int k2, int k3, int k4, int k5);
        logic [IW*OP_W-1:0] v;
        int ks [IW];
        ks = '{k0, k1, k2, k3, k4, k5};
        v = '0;
        for (int i = 0; i < IW; i++)
            if (i < n) v[i*OP_W +: OP_W] = opv(ks[i]);
        return v;
    endfunction

    task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(logic [BUNDLE_W-1:0] b);
        @(negedge clk);
        in_valid  = 1'b1;
        in_bundle = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic expect_group(string req, int n, logic [IW*CLS_W-1:0] cls,
                                logic [IW*OP_W-1:0] ops);
        @(negedge clk);
        chk({req, " out_valid"}, 256'(out_valid), 256'(1));
        chk({req, " lanes"}, 256'(out_slot_valid), 256'((1 << n) - 1));
        chk({req, " classes"}, 256'(out_slot_class), 256'(cls));
        chk({req, " ops"}, 256'(out_slot_op), 256'(ops));
        out_ready = 1'b1;
        @(posedge clk);
        #1;
        out_ready = 1'b0;
    endtask

    task automatic expect_idle(string req);
        @(negedge clk);
        chk({req, " idle"}, 256'(out_valid), 256'(0));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 out_valid", 256'(out_valid), 256'(0));
        chk("R10 in_ready", 256'(in_ready), 256'(1));
        chk("R10 bad_bundle", 256'(bad_bundle), 256'(0));
    endtask

    task automatic t_single();
        push(mkb(5'd0, 10));
        expect_group("R1 R2 single MII", 3, cv(1,0,0,0,0,0), ov(3, 10,11,12,0,0,0));
        expect_idle("R9 single drained");
    endtask

    task automatic t_unit_cap();
        push(mkb(5'd0, 20));
        push(mkb(5'd8, 30));
        @(negedge clk);
        chk("R8 full queue in_ready", 256'(in_ready), 256'(0));
        push(mkb(5'd0, 40));
        expect_group("R6 R9 cap on third INT", 5, cv(1,0,0,1,2,0), ov(5, 20,21,22,30,31,0));
        expect_group("R6 carried INT", 1, cv(0,0,0,0,0,0), ov(1, 32,0,0,0,0,0));
        expect_idle("R8 refused bundle absent");
    endtask

    task automatic t_mid_stop();
        push(mkb(5'd2, 50));
        push(mkb(5'd8, 60));
        expect_group("R4 mid barrier", 2, cv(1,0,0,0,0,0), ov(2, 50,51,0,0,0,0));
        expect_group("R4 leftover leads", 4, cv(0,1,2,0,0,0), ov(4, 52,60,61,62,0,0));
        expect_idle("R4 drained");
    endtask

    task automatic t_end_stop();
        push(mkb(5'd1, 70));
        push(mkb(5'd12, 80));
        expect_group("R3 end barrier", 3, cv(1,0,0,0,0,0), ov(3, 70,71,72,0,0,0));
        expect_group("R3 next bundle", 3, cv(1,0,3,0,0,0), ov(3, 80,81,82,0,0,0));
    endtask

    task automatic t_full_six();
        push(mkb(5'd8, 90));
        push(mkb(5'd12, 100));
        expect_group("R5 six across bundles", 6, cv(1,2,0,1,0,3), ov(6, 90,91,92,100,101,102));
        expect_idle("R5 drained");
    endtask

    task automatic t_patterns();
        push(mkb(5'd4, 120));
        expect_group("R2 pattern 1", 3, cv(1,1,0,0,0,0), ov(3, 120,121,122,0,0,0));
        push(mkb(5'd16, 130));
        expect_group("R2 pattern 4", 3, cv(1,2,3,0,0,0), ov(3, 130,131,132,0,0,0));
        push(mkb(5'd20, 140));
        expect_group("R2 pattern 5", 3, cv(0,0,3,0,0,0), ov(3, 140,141,142,0,0,0));
        push(mkb(5'd24, 150));
        expect_group("R2 pattern 6", 3, cv(1,1,2,0,0,0), ov(3, 150,151,152,0,0,0));
    endtask

    task automatic t_illegal();
        push(mkb(5'd31, 160));
        @(negedge clk);
        chk("R7 bad_bundle raised", 256'(bad_bundle), 256'(1));
        chk("R7 nothing issued", 256'(out_valid), 256'(0));
        @(negedge clk);
        chk("R7 bad_bundle single cycle", 256'(bad_bundle), 256'(0));
        chk("R7 in_ready kept", 256'(in_ready), 256'(1));
    endtask

    task automatic t_concurrent();
        push(mkb(5'd1, 170));
        @(negedge clk);
        in_valid  = 1'b1;
        in_bundle = mkb(5'd0, 180);
        out_ready = 1'b1;
        chk("R11 ready while issuing", 256'(in_ready), 256'(1));
        chk("R11 first group", 256'(out_slot_op), 256'(ov(3, 170,171,172,0,0,0)));
        @(posedge clk);
        #1;
        in_valid  = 1'b0;
        out_ready = 1'b0;
        expect_group("R11 appended bundle", 3, cv(1,0,0,0,0,0), ov(3, 180,181,182,0,0,0));
        expect_idle("R11 drained");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_unit_cap();
        t_mid_stop();
        t_end_stop();
        t_full_six();
        t_patterns();
        t_illegal();
        t_concurrent();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule